// File: doc/BRIEF.md
# Hardware-triggered channel access arbiter

This block is the front end of a serial controller that reaches registers on an analog companion chip. It offers 50 request channels. Channel ids 0 and 1 are software channels: a requester presents an address, a read/write flag and write data together with a request pulse. Channel ids 2 to 49 are hardware channels. Each one holds a single analog-chip address, programmed at configuration time. A pulse on the channel's trigger line alone queues a read of that address, so another on-chip unit can start a complete bus access without software.

Every channel keeps a pending flag and a snapshot of the command it queued. One command slot faces the serial side. Whenever the slot is empty, or is being emptied in this cycle, the block picks the next pending channel and loads the slot. Software channels always win over hardware channels. Within each group the choice rotates round-robin. The serial shifter takes a command with a one-cycle accept pulse, and that pulse clears the channel's pending flag.

Top module: `chan_access_arb`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, cmd_valid is 0, no channel is pending and every hardware channel is unmapped.
- R2: A cycle with cfg_we high and cfg_ch between 2 and 49 stores cfg_addr as that channel's mapped address and cfg_en as its mapped flag. A cfg_we cycle with cfg_ch of 0, 1 or 50 to 63 changes nothing. A trigger arriving in the same cycle as a configuration write is judged against the old configuration.
- R3: A pulse on hw_trig bit i of a mapped channel queues a command with cmd_ch = i + 2, cmd_addr equal to the mapped address at the time of the trigger, cmd_wr = 0 and cmd_wdata = 0.
- R4: A trigger on a hardware channel whose mapped flag is 0 produces no command.
- R5: Any further trigger on a channel that is already pending merges into the one pending request, so that channel produces exactly one command. A trigger in the same cycle as the accept of that channel's command starts a new request.
- R6: A configuration write to a pending channel does not change the command that channel already queued. Its next trigger uses the new address.
- R7: A pulse on sw_req bit s (s = 0 or 1) queues a command with cmd_ch = s and the values on sw_addr, sw_wr and sw_wdata in that cycle. A pulse on a pending software channel is ignored.
- R8: When the slot is loaded and any software channel is eligible, a software channel is chosen before any hardware channel.
- R9: Within each group the grant rotates. After channel g of a group is chosen, the next choice from that group is the first eligible channel after g, counting upward and wrapping around.
- R10: The command fields stay stable while cmd_valid is 1 and cmd_accept is 0. An accept (cmd_valid and cmd_accept both 1) clears that channel's pending flag, and the next command can be valid in the very next cycle. A request made in cycle t, with the slot empty, reaches cmd_valid two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 6 | Channel id addressed by the configuration write |
| cfg_addr | input | 17 | Analog-chip address to bind to the channel |
| cfg_en | input | 1 | Mapped flag written with the address |
| hw_trig | input | 48 | Trigger pulses; bit i belongs to channel id i+2 |
| sw_req | input | 2 | Request pulses of software channels 0 and 1 |
| sw_addr | input | 17 | Address of a software request |
| sw_wr | input | 1 | 1 for a write, 0 for a read, software request |
| sw_wdata | input | 16 | Write data of a software request |
| cmd_valid | output | 1 | Command slot holds a command |
| cmd_ch | output | 6 | Channel id of the command |
| cmd_addr | output | 17 | Analog-chip address of the command |
| cmd_wr | output | 1 | Read/write flag of the command |
| cmd_wdata | output | 16 | Write data of the command |
| cmd_accept | input | 1 | One-cycle acceptance pulse from the serial port |

## Verification
The hardest situations to reach are collisions in a single cycle. These include a trigger landing on the very cycle its channel's command is accepted, a configuration write hitting a channel that is pending or is triggered in the same cycle, and a software request arriving while hardware commands are queued. Directed sequences hold accept low to build up a backlog. They then retrigger and rewrite a pending channel, and release accepts one at a time. A long random phase follows that drives sparse triggers, software requests, configuration writes to any id and random accepts at once. A behavioural model tracks every pending flag and queued command, and on each cycle it checks the slot contents against the one expected.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;
  localparam int unsigned DEF_SW_CH  = 2;
  localparam int unsigned DEF_HW_CH  = 48;
  localparam int unsigned DEF_ADDR_W = 17;
  localparam int unsigned DEF_DATA_W = 16;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SW   = 2'd1,
    SRC_HW   = 2'd2
  } pick_src_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] idx
);
  // search starts one past the last grant and wraps
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 1; k <= N; k++) begin
      if (!any && req[(int'(last) + k) % N]) begin
        any = 1'b1;
        idx = IW'((int'(last) + k) % N);
      end
    end
  end
endmodule

// File: rtl/hw_chan_cell.sv
module hw_chan_cell #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hit,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              trig,
  input  logic              clr,
  output logic              pend,
  output logic [ADDR_W-1:0] q_addr
);
  logic              map_en_q, map_en_d;
  logic [ADDR_W-1:0] map_addr_q, map_addr_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] q_addr_q, q_addr_d;
  logic              fire, free;

  always_comb begin
    map_en_d   = map_en_q;
    map_addr_d = map_addr_q;
    if (cfg_hit) begin
      map_en_d   = cfg_en;
      map_addr_d = cfg_addr;
    end
    // a trigger is judged against the configuration before this cycle's write
    fire     = trig && map_en_q;
    free     = !pend_q || clr;
    pend_d   = pend_q;
    q_addr_d = q_addr_q;
    if (fire && free) begin
      pend_d   = 1'b1;
      q_addr_d = map_addr_q;
    end else if (clr) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_en_q   <= 1'b0;
      map_addr_q <= '0;
      pend_q     <= 1'b0;
      q_addr_q   <= '0;
    end else begin
      map_en_q   <= map_en_d;
      map_addr_q <= map_addr_d;
      pend_q     <= pend_d;
      q_addr_q   <= q_addr_d;
    end
  end

  assign pend   = pend_q;
  assign q_addr = q_addr_q;
endmodule

// File: rtl/sw_chan_cell.sv
module sw_chan_cell #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  output logic              pend,
  output logic [ADDR_W-1:0] q_addr,
  output logic              q_wr,
  output logic [DATA_W-1:0] q_wdata
);
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              take;

  always_comb begin
    take    = req && (!pend_q || clr);
    pend_d  = pend_q;
    addr_d  = addr_q;
    wr_d    = wr_q;
    wdata_d = wdata_q;
    if (take) begin
      pend_d  = 1'b1;
      addr_d  = addr;
      wr_d    = wr;
      wdata_d = wdata;
    end else if (clr) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      pend_q  <= pend_d;
      addr_q  <= addr_d;
      wr_q    <= wr_d;
      wdata_q <= wdata_d;
    end
  end

  assign pend    = pend_q;
  assign q_addr  = addr_q;
  assign q_wr    = wr_q;
  assign q_wdata = wdata_q;
endmodule

// File: rtl/chan_access_arb.sv
module chan_access_arb
  import chan_arb_pkg::*;
#(
  parameter  int NUM_SW = DEF_SW_CH,
  parameter  int NUM_HW = DEF_HW_CH,
  parameter  int ADDR_W = DEF_ADDR_W,
  parameter  int DATA_W = DEF_DATA_W,
  localparam int NUM_CH = NUM_SW + NUM_HW,
  localparam int ID_W   = $clog2(NUM_CH),
  localparam int SW_IW  = (NUM_SW > 1) ? $clog2(NUM_SW) : 1,
  localparam int HW_IW  = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ID_W-1:0]   cfg_ch,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_en,
  input  logic [NUM_HW-1:0] hw_trig,
  input  logic [NUM_SW-1:0] sw_req,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic              cmd_valid,
  output logic [ID_W-1:0]   cmd_ch,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_wr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_accept
);
  logic [NUM_CH-1:0]             pend_all;
  logic [NUM_CH-1:0]             clr_vec;
  logic [NUM_CH-1:0]             elig;
  logic [NUM_CH-1:0][ADDR_W-1:0] q_addr_all;
  logic [NUM_CH-1:0]             q_wr_all;
  logic [NUM_CH-1:0][DATA_W-1:0] q_wdata_all;

  logic              valid_q, valid_d;
  logic [ID_W-1:0]   ch_q, ch_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [SW_IW-1:0]  sw_last_q, sw_last_d, sw_idx;
  logic [HW_IW-1:0]  hw_last_q, hw_last_d, hw_idx;
  logic              sw_any, hw_any;
  logic              accepted, load;
  pick_src_e         src;
  int                win_ch;

  assign accepted = valid_q && cmd_accept;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      clr_vec[c] = accepted && (int'(ch_q) == c);
    end
  end

  // the channel leaving the slot this cycle may not be picked again
  assign elig = pend_all & ~clr_vec;

  for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
    sw_chan_cell #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (sw_req[s]),
      .addr    (sw_addr),
      .wr      (sw_wr),
      .wdata   (sw_wdata),
      .clr     (clr_vec[s]),
      .pend    (pend_all[s]),
      .q_addr  (q_addr_all[s]),
      .q_wr    (q_wr_all[s]),
      .q_wdata (q_wdata_all[s])
    );
  end

  for (genvar h = 0; h < NUM_HW; h++) begin : g_hw
    logic hit;
    assign hit = cfg_we && (int'(cfg_ch) == h + NUM_SW);
    hw_chan_cell #(.ADDR_W(ADDR_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_hit  (hit),
      .cfg_en   (cfg_en),
      .cfg_addr (cfg_addr),
      .trig     (hw_trig[h]),
      .clr      (clr_vec[h+NUM_SW]),
      .pend     (pend_all[h+NUM_SW]),
      .q_addr   (q_addr_all[h+NUM_SW])
    );
    assign q_wr_all[h+NUM_SW]    = 1'b0;
    assign q_wdata_all[h+NUM_SW] = '0;
  end

  rr_pick #(.N(NUM_SW)) u_sw_rr (
    .req  (elig[NUM_SW-1:0]),
    .last (sw_last_q),
    .any  (sw_any),
    .idx  (sw_idx)
  );

  rr_pick #(.N(NUM_HW)) u_hw_rr (
    .req  (elig[NUM_CH-1:NUM_SW]),
    .last (hw_last_q),
    .any  (hw_any),
    .idx  (hw_idx)
  );

  always_comb begin
    load   = !valid_q || accepted;
    src    = SRC_NONE;
    win_ch = 0;
    if (load && sw_any) begin
      src    = SRC_SW;
      win_ch = int'(sw_idx);
    end else if (load && hw_any) begin
      src    = SRC_HW;
      win_ch = int'(hw_idx) + NUM_SW;
    end

    valid_d   = valid_q;
    ch_d      = ch_q;
    addr_d    = addr_q;
    wr_d      = wr_q;
    wdata_d   = wdata_q;
    sw_last_d = sw_last_q;
    hw_last_d = hw_last_q;
    if (load) begin
      valid_d = (src != SRC_NONE);
    end
    if (src != SRC_NONE) begin
      ch_d    = ID_W'(win_ch);
      addr_d  = q_addr_all[win_ch];
      wr_d    = q_wr_all[win_ch];
      wdata_d = q_wdata_all[win_ch];
    end
    if (src == SRC_SW) sw_last_d = sw_idx;
    if (src == SRC_HW) hw_last_d = hw_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      ch_q      <= '0;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      sw_last_q <= SW_IW'(NUM_SW - 1);
      hw_last_q <= HW_IW'(NUM_HW - 1);
    end else begin
      valid_q   <= valid_d;
      ch_q      <= ch_d;
      addr_q    <= addr_d;
      wr_q      <= wr_d;
      wdata_q   <= wdata_d;
      sw_last_q <= sw_last_d;
      hw_last_q <= hw_last_d;
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_ch    = ch_q;
  assign cmd_addr  = addr_q;
  assign cmd_wr    = wr_q;
  assign cmd_wdata = wdata_q;
endmodule

// File: rtl/chan_access_arb_chk.sv
module chan_access_arb_chk #(
  parameter  int NUM_SW = 2,
  parameter  int NUM_HW = 48,
  parameter  int ADDR_W = 17,
  parameter  int DATA_W = 16,
  localparam int NUM_CH = NUM_SW + NUM_HW,
  localparam int ID_W   = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [ID_W-1:0]   cmd_ch,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_wr,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              cmd_accept,
  input logic [NUM_CH-1:0] pend_all
);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_accept |=> cmd_valid && $stable(cmd_ch) && $stable(cmd_addr)
                                  && $stable(cmd_wr) && $stable(cmd_wdata));

  assert_slot_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (int'(cmd_ch) < NUM_CH) && pend_all[cmd_ch]);

  assert_hw_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (int'(cmd_ch) >= NUM_SW) |-> !cmd_wr && (cmd_wdata == '0));

  assert_sw_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && (|pend_all[NUM_SW-1:0]) |=> cmd_valid && (int'(cmd_ch) < NUM_SW));
endmodule

bind chan_access_arb chan_access_arb_chk #(
  .NUM_SW (NUM_SW),
  .NUM_HW (NUM_HW),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ch     (cmd_ch),
  .cmd_addr   (cmd_addr),
  .cmd_wr     (cmd_wr),
  .cmd_wdata  (cmd_wdata),
  .cmd_accept (cmd_accept),
  .pend_all   (pend_all)
);

// File: tb/chan_access_arb_bench.sv
`timescale 1ns/1ps
module chan_access_arb_bench;
  localparam int NSW = 2;
  localparam int NHW = 48;
  localparam int NCH = 50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [5:0]  cfg_ch;
  logic [16:0] cfg_addr;
  logic        cfg_en;
  logic [47:0] hw_trig;
  logic [1:0]  sw_req;
  logic [16:0] sw_addr;
  logic        sw_wr;
  logic [15:0] sw_wdata;
  logic        cmd_valid;
  logic [5:0]  cmd_ch;
  logic [16:0] cmd_addr;
  logic        cmd_wr;
  logic [15:0] cmd_wdata;
  logic        cmd_accept;

  chan_access_arb u_chan_access_arb (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_addr(cfg_addr),
    .cfg_en(cfg_en), .hw_trig(hw_trig), .sw_req(sw_req), .sw_addr(sw_addr),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .cmd_valid(cmd_valid), .cmd_ch(cmd_ch),
    .cmd_addr(cmd_addr), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_accept(cmd_accept)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    done   = 0;
  bit    cmp_on = 0;
  int    acc_mode = 0;
  string tag = "R1";

  // reference model state
  bit m_pend [NCH];
  int m_qaddr[NCH];
  bit m_qwr  [NCH];
  int m_qdata[NCH];
  bit m_map  [NCH];
  int m_maddr[NCH];
  bit m_sv;
  int m_sch, m_saddr, m_sdata;
  bit m_swr;
  int m_swlast, m_hwlast;
  int acc_cnt [NCH];
  int last_acc[NCH];
  bit acc;
  int win, cc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m_pend[c] = 0; m_map[c] = 0; end
      m_sv = 0; m_swlast = NSW - 1; m_hwlast = NHW - 1;
    end else begin
      acc = m_sv && cmd_accept;
      if (acc) begin acc_cnt[m_sch]++; last_acc[m_sch] = m_saddr; end
      win = -1;
      if (!m_sv || acc) begin
        for (int k = 1; k <= NSW; k++) begin
          cc = (m_swlast + k) % NSW;
          if (win < 0 && m_pend[cc] && !(acc && m_sch == cc)) win = cc;
        end
        if (win >= 0) m_swlast = win;
        else begin
          for (int k = 1; k <= NHW; k++) begin
            cc = NSW + (m_hwlast + k) % NHW;
            if (win < 0 && m_pend[cc] && !(acc && m_sch == cc)) win = cc;
          end
          if (win >= 0) m_hwlast = win - NSW;
        end
      end
      // channel updates use the state before this edge
      for (int c = NSW; c < NCH; c++) begin
        if (hw_trig[c-NSW] && m_map[c] && (!m_pend[c] || (acc && m_sch == c))) begin
          m_pend[c] = 1; m_qaddr[c] = m_maddr[c]; m_qwr[c] = 0; m_qdata[c] = 0;
        end else if (acc && m_sch == c) m_pend[c] = 0;
      end
      for (int s = 0; s < NSW; s++) begin
        if (sw_req[s] && (!m_pend[s] || (acc && m_sch == s))) begin
          m_pend[s] = 1; m_qaddr[s] = sw_addr; m_qwr[s] = sw_wr; m_qdata[s] = sw_wdata;
        end else if (acc && m_sch == s) m_pend[s] = 0;
      end
      if (cfg_we && cfg_ch >= NSW && cfg_ch < NCH) begin
        m_map[cfg_ch] = cfg_en; m_maddr[cfg_ch] = cfg_addr;
      end
      if (!m_sv || acc) begin
        if (win >= 0) begin
          m_sv = 1; m_sch = win; m_saddr = m_qaddr[win]; m_swr = m_qwr[win]; m_sdata = m_qdata[win];
        end else m_sv = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (cmd_valid !== m_sv ||
          (m_sv && (cmd_ch !== 6'(m_sch) || cmd_addr !== 17'(m_saddr) ||
                    cmd_wr !== m_swr || cmd_wdata !== 16'(m_sdata)))) begin
        fails++;
        $display("FAIL %s cycle %0d: actual valid=%0b ch=%0d addr=%h wr=%0b data=%h expected valid=%0b ch=%0d addr=%h wr=%0b data=%h",
                 tag, cyc, cmd_valid, cmd_ch, cmd_addr, cmd_wr, cmd_wdata,
                 m_sv, m_sch, m_saddr[16:0], m_swr, m_sdata[15:0]);
      end
    end
  end

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL R10 watchdog: actual cycles=%0d expected below 100000", cyc);
      summary();
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      cmd_accept = (acc_mode == 1) || (acc_mode == 2 && ($urandom % 3) == 0);
      @(negedge clk);
    end
  endtask

  task automatic cfg(int id, int a, bit en);
    cfg_we = 1; cfg_ch = 6'(id); cfg_addr = 17'(a); cfg_en = en;
    tick();
    cfg_we = 0;
  endtask

  task automatic trig(int id);
    hw_trig = '0; hw_trig[id-NSW] = 1'b1;
    tick();
    hw_trig = '0;
  endtask

  int total;

  initial begin
    rst_n = 0; cfg_we = 0; cfg_ch = 0; cfg_addr = 0; cfg_en = 0; hw_trig = '0;
    sw_req = '0; sw_addr = 0; sw_wr = 0; sw_wdata = 0; cmd_accept = 0;
    for (int c = 0; c < NCH; c++) begin acc_cnt[c] = 0; last_acc[c] = 0; end
    repeat (3) @(negedge clk);
    tag = "R1"; cmp_on = 1;
    tick(2);
    rst_n = 1;
    chk("R1 cmd_valid after reset", cmd_valid, 0);
    tick();
    chk("R1 cmd_valid first cycle", cmd_valid, 0);

    // R2 / R4 / R9: mapping decode, unmapped triggers, rotation order
    tag = "R2";
    cfg(2, 'h00011, 1); cfg(3, 'h10203, 1); cfg(10, 'h1ABCD, 1);
    cfg(30, 'h08C20, 1); cfg(49, 'h1FFFF, 1);
    cfg(1, 'h00123, 1); cfg(51, 'h00777, 1); cfg(0, 'h00456, 1);
    tag = "R9"; acc_mode = 1;
    hw_trig = '1; tick(); hw_trig = '0;
    tick(30);
    total = 0;
    for (int c = 0; c < NCH; c++) total += acc_cnt[c];
    chk("R4 only mapped channels issue", total, 5);
    chk("R2 id 1 not bound", acc_cnt[1], 0);
    chk("R2 id 3 bound", last_acc[3], 'h10203);

    // R10 latency and hold, R5 merge, R6 snapshot
    tag = "R10"; acc_mode = 0;
    for (int c = 0; c < NCH; c++) acc_cnt[c] = 0;
    hw_trig[10-NSW] = 1'b1; tick(); hw_trig = '0;
    chk("R10 not valid one edge after trigger", cmd_valid, 0);
    tick();
    chk("R10 valid two edges after trigger", cmd_valid, 1);
    chk("R3 channel id", cmd_ch, 10);
    tag = "R5";
    trig(10); tick(2); trig(10);
    tag = "R6";
    cfg(10, 'h05555, 1);
    tick(3);
    chk("R6 queued address kept", cmd_addr, 'h1ABCD);
    acc_mode = 1; tick(8);
    chk("R5 merged into one command", acc_cnt[10], 1);
    trig(10); tick(6);
    chk("R6 next trigger uses new address", last_acc[10], 'h05555);

    // R5 retrigger on the accept cycle
    tag = "R5"; acc_mode = 0;
    trig(49); tick(2);
    acc_mode = 1; hw_trig[49-NSW] = 1'b1; tick(); hw_trig = '0; acc_mode = 0;
    tick(2);
    chk("R5 new request after accept", cmd_valid, 1);
    acc_mode = 1; tick(4);

    // R7 software capture
    tag = "R7"; acc_mode = 0;
    sw_req = 2'b01; sw_addr = 'h00400; sw_wr = 1; sw_wdata = 'hBEEF; tick();
    sw_addr = 'h00999; sw_wdata = 'h1234; tick();
    sw_req = 0; tick(2);
    chk("R7 data captured first", cmd_wdata, 'hBEEF);
    chk("R7 write flag", cmd_wr, 1);
    acc_mode = 1; tick(4);

    // R8 software priority over queued hardware
    tag = "R8"; acc_mode = 0;
    hw_trig[0] = 1'b1; hw_trig[1] = 1'b1; tick(); hw_trig = '0;
    tick(2);
    sw_req = 2'b11; sw_wr = 0; sw_addr = 'h00042; tick(); sw_req = 0;
    acc_mode = 1; tick(); acc_mode = 0;
    tick();
    chk("R8 software next after accept", (cmd_ch < 2) ? 1 : 0, 1);
    acc_mode = 1; tick(10);

    // mixed random traffic
    tag = "R9"; acc_mode = 2;
    for (int i = 0; i < 4000; i++) begin
      for (int b = 0; b < NHW; b++) hw_trig[b] = (($urandom % 16) == 0);
      sw_req   = 2'(($urandom % 8) == 0 ? ($urandom % 4) : 0);
      sw_addr  = 17'($urandom); sw_wr = 1'($urandom); sw_wdata = 16'($urandom);
      cfg_we   = (($urandom % 10) == 0);
      cfg_ch   = 6'($urandom); cfg_addr = 17'($urandom); cfg_en = 1'($urandom);
      tick();
    end
    hw_trig = '0; sw_req = 0; cfg_we = 0;
    tag = "R10"; acc_mode = 1;
    tick(200);
    chk("R10 all drained", cmd_valid, 0);
    summary();
  end
endmodule